// File: doc/BRIEF.md
# Four-Bit ALU Slice with Lookahead Group Outputs

This block is a purely combinational arithmetic/logic slice. It takes two operands, a carry input and a three-bit operation code. It returns a result word, plus an active-low group propagate and an active-low group generate. A separate carry-lookahead unit combines those two outputs when several slices are joined into a wider datapath. The slice makes no ripple carry-out and no overflow flag. The lookahead unit forms the carry into the next slice from the group signals and the carry input.

There are eight operation codes. Three are arithmetic: addition and two subtraction directions. Three are bitwise: exclusive-or, inclusive-or and and. The last two drive the result to all zeros or to all ones. Each subtraction adds the minuend to the one's complement of the subtrahend and then adds the carry input. The least significant slice must therefore receive a carry of 1 to give a two's-complement difference. The operand width is a parameter and defaults to four bits.

Top module: `lookahead_alu_slice`

## Requirements
- R1: With `op_sel_i` = 3'b000, `res_o` is all zeros and both `grp_prop_n_o` and `grp_gen_n_o` are 1, whatever the operands and carry.
- R2: With `op_sel_i` = 3'b111, `res_o` is all ones and both group outputs are 1, whatever the operands and carry.
- R3: With `op_sel_i` = 3'b011, `res_o` = (A + B + cin) modulo 2^WIDTH.
- R4: With `op_sel_i` = 3'b001, `res_o` = (B + ~A + cin) modulo 2^WIDTH, so cin = 1 yields B minus A.
- R5: With `op_sel_i` = 3'b010, `res_o` = (A + ~B + cin) modulo 2^WIDTH, so cin = 1 yields A minus B.
- R6: Codes 3'b100, 3'b101 and 3'b110 give bitwise A XOR B, A OR B and A AND B respectively, and `cin_i` has no effect on `res_o`.
- R7: In the three arithmetic codes, `grp_gen_n_o` is 0 exactly when the applied operands X and Y (after any inversion for subtraction) satisfy X + Y >= 2^WIDTH.
- R8: In the three arithmetic codes, `grp_prop_n_o` is 0 exactly when every bit of X XOR Y is 1.
- R9: In the three bitwise codes, both group outputs are 1 and do not depend on `cin_i`.
- R10: In the arithmetic codes, (NOT `grp_gen_n_o`) OR ((NOT `grp_prop_n_o`) AND `cin_i`) equals bit WIDTH of X + Y + cin, which is the slice's carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel_i | input | 3 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry into the least significant bit |
| res_o | output | WIDTH | Result word |
| grp_prop_n_o | output | 1 | Group carry propagate, active low |
| grp_gen_n_o | output | 1 | Group carry generate, active low |

## Verification
The bench builds the slice with the default WIDTH of 4. At that width the input space is only 8 codes × 256 operand pairs × 2 carries, so the bench applies every combination. Each combination is compared against an independent integer model of the result, both group outputs and the carry recomposed from them. A short table of hand-worked vectors comes first. It covers the subtraction boundaries: equal operands, a borrow, and a zero minuend with no carry.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR   = 3'b000,
    OP_B_SUB_A = 3'b001,
    OP_A_SUB_B = 3'b010,
    OP_ADD     = 3'b011,
    OP_XOR     = 3'b100,
    OP_OR      = 3'b101,
    OP_AND     = 3'b110,
    OP_PRESET  = 3'b111
  } alu_op_e;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op == OP_B_SUB_A) || (op == OP_A_SUB_B) || (op == OP_ADD);
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o
);

  // Invert the subtrahend; the carry input supplies the +1.
  always_comb begin
    unique case (op_i)
      OP_B_SUB_A: begin x_o = ~a_i; y_o = b_i;  end
      OP_A_SUB_B: begin x_o = a_i;  y_o = ~b_i; end
      default:    begin x_o = a_i;  y_o = b_i;  end
    endcase
  end

endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] bit_p_o,
  output logic [WIDTH-1:0] bit_g_o,
  output logic             cout_o
);

  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_p_o[i]  = x_i[i] ^ y_i[i];
    assign bit_g_o[i]  = x_i[i] & y_i[i];
    assign sum_o[i]    = bit_p_o[i] ^ carry[i];
    assign carry[i+1]  = bit_g_o[i] | (bit_p_o[i] & carry[i]);
  end

  assign cout_o = carry[WIDTH];

  logic [EXT_W-1:0] wide_sum;
  assign wide_sum = EXT_W'(x_i) + EXT_W'(y_i) + EXT_W'(cin_i);

  // R3
  always_comb begin
    chain_sum_chk: assert ({cout_o, sum_o} == wide_sum);
  end

endmodule

// File: rtl/alu_group_pg.sv
module alu_group_pg #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] bit_p_i,
  input  logic [WIDTH-1:0] bit_g_i,
  output logic             grp_p_o,
  output logic             grp_g_o
);

  // Fold from LSB upward: G = g[n] | p[n] & G_below.
  always_comb begin
    grp_p_o = 1'b1;
    grp_g_o = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      grp_g_o = bit_g_i[i] | (bit_p_i[i] & grp_g_o);
      grp_p_o = grp_p_o & bit_p_i[i];
    end
  end

  // R7 R8: full propagate and any generate cannot coexist
  always_comb begin
    pg_excl_chk: assert (!(grp_p_o && grp_g_o));
  end

endmodule

// File: rtl/lookahead_alu_slice.sv
module lookahead_alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       op_sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             grp_prop_n_o,
  output logic             grp_gen_n_o
);

  alu_op_e op;
  logic    arith;
  assign op    = alu_op_e'(op_sel_i);
  assign arith = op_is_arith(op);

  logic [WIDTH-1:0] opnd_x, opnd_y, sum, bit_p, bit_g;
  logic             chain_cout, grp_p, grp_g;

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .op_i(op), .a_i(a_i), .b_i(b_i), .x_o(opnd_x), .y_o(opnd_y)
  );

  alu_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i(opnd_x), .y_i(opnd_y), .cin_i(cin_i),
    .sum_o(sum), .bit_p_o(bit_p), .bit_g_o(bit_g), .cout_o(chain_cout)
  );

  alu_group_pg #(.WIDTH(WIDTH)) u_pg (
    .bit_p_i(bit_p), .bit_g_i(bit_g), .grp_p_o(grp_p), .grp_g_o(grp_g)
  );

  always_comb begin
    unique case (op)
      OP_CLEAR:  res_o = '0;
      OP_XOR:    res_o = a_i ^ b_i;
      OP_OR:     res_o = a_i | b_i;
      OP_AND:    res_o = a_i & b_i;
      OP_PRESET: res_o = '1;
      default:   res_o = sum;
    endcase
  end

  // Only arithmetic codes may present a carry to the lookahead unit.
  assign grp_prop_n_o = ~(arith & grp_p);
  assign grp_gen_n_o  = ~(arith & grp_g);

  always_comb begin
    // R1
    if (op == OP_CLEAR)
      clear_out_chk: assert (res_o == '0 && grp_prop_n_o && grp_gen_n_o);
    // R2
    if (op == OP_PRESET)
      preset_out_chk: assert (res_o == '1 && grp_prop_n_o && grp_gen_n_o);
    // R9
    if (!arith)
      pg_idle_chk: assert (grp_prop_n_o && grp_gen_n_o);
    // R10
    if (arith)
      ext_carry_chk: assert ((!grp_gen_n_o || (!grp_prop_n_o && cin_i)) == chain_cout);
  end

endmodule

// File: tb/lookahead_alu_slice_bench.sv
module lookahead_alu_slice_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NVEC = 11;

  // {sel[2:0], a[3:0], b[3:0], cin, f[3:0], prop_n, gen_n}
  localparam logic [17:0] VEC [NVEC] = '{
    {3'b000, 4'h9, 4'h6, 1'b1, 4'h0, 1'b1, 1'b1},  // R1 clear
    {3'b111, 4'h3, 4'h4, 1'b0, 4'hF, 1'b1, 1'b1},  // R2 preset
    {3'b011, 4'h7, 4'h8, 1'b0, 4'hF, 1'b0, 1'b1},  // R3 R8 full propagate
    {3'b011, 4'h9, 4'h9, 1'b1, 4'h3, 1'b1, 1'b0},  // R3 R7 generate
    {3'b001, 4'h3, 4'hA, 1'b1, 4'h7, 1'b1, 1'b0},  // R4 B-A
    {3'b010, 4'h3, 4'hA, 1'b1, 4'h9, 1'b1, 1'b1},  // R5 A-B borrow
    {3'b010, 4'h5, 4'h5, 1'b1, 4'h0, 1'b0, 1'b1},  // R5 equal operands
    {3'b100, 4'hC, 4'hA, 1'b1, 4'h6, 1'b1, 1'b1},  // R6 xor
    {3'b101, 4'hC, 4'hA, 1'b0, 4'hE, 1'b1, 1'b1},  // R6 or
    {3'b110, 4'hC, 4'hA, 1'b1, 4'h8, 1'b1, 1'b1},  // R6 and
    {3'b001, 4'h0, 4'h0, 1'b0, 4'hF, 1'b0, 1'b1}   // R4 no carry in
  };

  logic clk = 1'b0;
  logic rst;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]   sel;
  logic [W-1:0] a, b, f;
  logic         cin, prop_n, gen_n;
  int checks = 0;
  int errors = 0;

  lookahead_alu_slice #(.WIDTH(W)) u_lookahead_alu_slice (
    .op_sel_i(sel), .a_i(a), .b_i(b), .cin_i(cin),
    .res_o(f), .grp_prop_n_o(prop_n), .grp_gen_n_o(gen_n)
  );

  function automatic string res_req(input logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R3";
      3'd7: return "R2";
      default: return "R6";
    endcase
  endfunction

  function automatic string pg_req(input logic [2:0] s, input bit is_gen);
    if (s == 3'd0) return "R1";
    if (s == 3'd7) return "R2";
    if (s >= 3'd4) return "R9";
    return is_gen ? "R7" : "R8";
  endfunction

  // Independent integer model: {f, prop_n, gen_n, cout}
  function automatic logic [6:0] model(input logic [2:0] s, input int av,
                                       input int bv, input int c);
    int x, y, full;
    logic [3:0] r;
    logic pn, gn, co;
    x = av; y = bv;
    if (s == 3'd1) x = 15 - av;
    if (s == 3'd2) y = 15 - bv;
    full = x + y + c;
    pn = 1'b1; gn = 1'b1; co = 1'b0;
    case (s)
      3'd0: r = 4'h0;
      3'd4: r = 4'(av ^ bv);
      3'd5: r = 4'(av | bv);
      3'd6: r = 4'(av & bv);
      3'd7: r = 4'hF;
      default: begin
        r  = 4'(full);
        gn = !((x + y) >= 16);
        pn = !((x ^ y) == 15);
        co = (full >= 16);
      end
    endcase
    return {r, pn, gn, co};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s sel=%0d a=%0h b=%0h cin=%0d actual=%0h expected=%0h",
               req, what, sel, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [3:0] av,
                       input logic [3:0] bv, input logic c);
    @(posedge clk);
    sel = s; a = av; b = bv; cin = c;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    sel = 3'd0; a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Initial state: clear code with zero inputs (R1)
    check("R1", "initial res", int'(f), 0);
    check("R1", "initial prop_n/gen_n", int'({prop_n, gen_n}), 3);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][17:15], VEC[i][14:11], VEC[i][10:7], VEC[i][6]);
      check(res_req(sel), "table res", int'(f), int'(VEC[i][5:2]));
      check(pg_req(sel, 1'b0), "table prop_n", int'(prop_n), int'(VEC[i][1]));
      check(pg_req(sel, 1'b1), "table gen_n", int'(gen_n), int'(VEC[i][0]));
    end

    for (int s = 0; s < 8; s++) begin
      for (int av = 0; av < 16; av++) begin
        for (int bv = 0; bv < 16; bv++) begin
          for (int c = 0; c < 2; c++) begin
            logic [6:0] m;
            apply(3'(s), 4'(av), 4'(bv), 1'(c));
            m = model(3'(s), av, bv, c);
            check(res_req(sel), "res", int'(f), int'(m[6:3]));
            check(pg_req(sel, 1'b0), "prop_n", int'(prop_n), int'(m[2]));
            check(pg_req(sel, 1'b1), "gen_n", int'(gen_n), int'(m[1]));
            if (s >= 1 && s <= 3)
              check("R10", "recomposed carry",
                    int'(!gen_n || (!prop_n && cin)), int'(m[0]));
          end
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule